// File: doc/BRIEF.md
# Page Fault Detector with Fault Address Register

This block decides whether one memory access must take a page fault. The page-table walk has already produced one entry per translation level, and the block receives the resolved bits of every level. These bits are the present flag, the write-permission flag, the user-access flag, the no-execute flag and a reserved-bits-set flag. Alongside them come the kind of access (read, write or instruction fetch), the privilege of the requester and the paging-extension flags. A faulting access produces a one-cycle fault pulse carrying vector 14 and a five-bit error code.

On the same clock edge, the block loads the faulting linear address into a 64-bit fault address register. Software can also write that register through a separate port. When the processor runs in legacy mode, only the low 32 bits of any value written to the register are kept, whichever source wrote it. The upper half is cleared.

Effective permissions are combined across the levels. An access is allowed to write, or to run at user privilege, only if every level allows it. A supervisor write to a read-only page faults only when write protection is enabled.

Top module: `page_fault_detector`

## Requirements
- R1: An access whose present bits are not all 1 faults. Its error code has bit0 (protection) = 0 and bit3 (reserved) = 0.
- R2: An instruction fetch (kind 2'b10) to a fully present walk where any level has the no-execute bit set faults. Bit4 of the error code is 1 exactly when the access is a fetch. A fetch with no no-execute bit set, and no other violation, does not fault.
- R3: A user access (acc_user = 1) faults when any level has its user flag at 0. Bit2 of the error code equals acc_user. A supervisor access ignores the user flags.
- R4: A write (kind 2'b01) to a walk where any level has its write flag at 0 behaves as follows. It always faults for a user access. For a supervisor access it faults only when wp_enable = 1. Bit1 of the error code is 1 exactly when the access is a write. Kinds 2'b00 and 2'b11 are reads.
- R5: A reserved-bit flag set on any level of a fully present walk faults only when cr4_pse = 1 or cr4_pae = 1. It then sets bit3 and bit0 of the error code. With both flags at 0, the reserved flags have no effect.
- R6: pf_valid is high for exactly the cycle after an accepted access (acc_valid = 1) that faults. pf_vector reads 14 while pf_valid is high and 0 otherwise. pf_errcode is loaded on a fault and holds its value otherwise.
- R7: On a fault outside legacy mode, cr2 takes the full 64-bit acc_addr in the same cycle that pf_valid rises.
- R8: In legacy mode, every value written into cr2, by a fault or by software, keeps bits 31:0 and has bits 63:32 cleared.
- R9: A software write (sw_cr2_we = 1) with no fault loads sw_cr2_wdata one cycle later. With neither a fault nor a software write, cr2 holds its value.
- R10: When a fault and a software write occur in the same cycle, cr2 takes the fault address and drops the software data.
- R11: While rst is high, and in the first cycle after it, pf_valid = 0, pf_errcode = 0 and cr2 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| acc_user | input | 1 | 1 = user privilege, 0 = supervisor |
| acc_addr | input | 64 | Linear address of the access |
| lvl_present | input | LEVELS | Present flag per level |
| lvl_writable | input | LEVELS | Write-permission flag per level |
| lvl_user | input | LEVELS | User-access flag per level |
| lvl_noexec | input | LEVELS | No-execute flag per level |
| lvl_rsvd | input | LEVELS | Reserved bits set, per level |
| cr4_pse | input | 1 | Page-size extension enable |
| cr4_pae | input | 1 | Physical-address extension enable |
| legacy_mode | input | 1 | Legacy mode: fault address register is 32-bit |
| wp_enable | input | 1 | Write protection applies to supervisor writes |
| sw_cr2_we | input | 1 | Software write strobe for the fault address register |
| sw_cr2_wdata | input | 64 | Software write data |
| pf_valid | output | 1 | Page fault pulse |
| pf_vector | output | 8 | 14 during a fault pulse, else 0 |
| pf_errcode | output | 5 | {fetch, reserved, user, write, protection} |
| cr2 | output | 64 | Fault address register |

## Verification
The assertions take for granted that the walk bits, the access kind and the mode flags are stable and meaningful whenever acc_valid is high. They also assume that a software write may land in the same cycle as any access. The stimulus drives every input half a cycle before the sampling edge and holds it until the next falling edge. It mixes directed cases with a random phase that draws all flags freely, including simultaneous faults and software writes and the unused access kind 2'b11. A behavioural model in the bench follows the same edges, so no assumption about inputs is ever broken.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    parameter int unsigned VA_W      = 64;
    parameter int unsigned LEG_W     = 32;
    parameter int unsigned ERR_W     = 5;
    parameter int unsigned VEC_W     = 8;
    parameter int unsigned PF_VECTOR = 14;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSV   = 2'b11
    } acc_kind_e;

    // packed MSB first: fetch is bit4, prot is bit0
    typedef struct packed {
        logic fetch;
        logic rsvd;
        logic user;
        logic write;
        logic prot;
    } pf_err_t;

    typedef struct packed {
        logic all_present;
        logic eff_write;
        logic eff_user;
        logic any_nx;
        logic any_rsvd;
    } walk_sum_t;

    function automatic logic [VA_W-1:0] cr2_mask(input logic [VA_W-1:0] v,
                                                 input logic leg);
        logic [VA_W-1:0] r;
        r = v;
        if (leg) r[VA_W-1:LEG_W] = '0;
        return r;
    endfunction

endpackage

// File: rtl/pfd_walk_merge.sv
module pfd_walk_merge
    import pfd_pkg::*;
#(
    parameter int unsigned LEVELS = 4
) (
    input  logic [LEVELS-1:0] present,
    input  logic [LEVELS-1:0] writable,
    input  logic [LEVELS-1:0] user,
    input  logic [LEVELS-1:0] noexec,
    input  logic [LEVELS-1:0] rsvd,
    output walk_sum_t         sum
);
    logic [LEVELS:0] p_c, w_c, u_c, nx_c, rs_c;

    assign p_c[0]  = 1'b1;
    assign w_c[0]  = 1'b1;
    assign u_c[0]  = 1'b1;
    assign nx_c[0] = 1'b0;
    assign rs_c[0] = 1'b0;

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        assign p_c[g+1]  = p_c[g]  & present[g];
        assign w_c[g+1]  = w_c[g]  & writable[g];
        assign u_c[g+1]  = u_c[g]  & user[g];
        assign nx_c[g+1] = nx_c[g] | noexec[g];
        assign rs_c[g+1] = rs_c[g] | rsvd[g];
    end

    assign sum.all_present = p_c[LEVELS];
    assign sum.eff_write   = w_c[LEVELS];
    assign sum.eff_user    = u_c[LEVELS];
    assign sum.any_nx      = nx_c[LEVELS];
    assign sum.any_rsvd    = rs_c[LEVELS];
endmodule

// File: rtl/pfd_fault_eval.sv
module pfd_fault_eval
    import pfd_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       is_user,
    input  walk_sum_t  sum,
    input  logic       pse,
    input  logic       pae,
    input  logic       wp,
    output logic       fault,
    output pf_err_t    err
);
    acc_kind_e k;
    logic is_write, is_fetch;
    logic rsvd_hit, us_viol, rw_viol, nx_viol;

    always_comb begin
        k        = acc_kind_e'(kind);
        is_write = (k == ACC_WRITE);
        is_fetch = (k == ACC_FETCH);
        rsvd_hit = sum.all_present & sum.any_rsvd & (pse | pae);
        us_viol  = is_user & ~sum.eff_user;
        rw_viol  = is_write & ~sum.eff_write & (is_user | wp);
        nx_viol  = is_fetch & sum.any_nx;
        fault    = ~sum.all_present | rsvd_hit
                 | (sum.all_present & (us_viol | rw_viol | nx_viol));
        err.prot  = sum.all_present;
        err.write = is_write;
        err.user  = is_user;
        err.rsvd  = rsvd_hit;
        err.fetch = is_fetch;
    end
endmodule

// File: rtl/pfd_cr2_reg.sv
module pfd_cr2_reg
    import pfd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            fault_wr,
    input  logic [VA_W-1:0] fault_addr,
    input  logic            sw_we,
    input  logic [VA_W-1:0] sw_data,
    input  logic            legacy,
    output logic [VA_W-1:0] cr2
);
    always_ff @(posedge clk) begin
        if (rst)           cr2 <= '0;
        else if (fault_wr) cr2 <= cr2_mask(fault_addr, legacy);
        else if (sw_we)    cr2 <= cr2_mask(sw_data, legacy);
    end

    // R8
    legacy_upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
        legacy && (fault_wr || sw_we) |=> cr2[VA_W-1:LEG_W] == '0);
    // R9
    cr2_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fault_wr && !sw_we |=> $stable(cr2));
    // R10
    fault_priority_chk: assert property (@(posedge clk) disable iff (rst)
        fault_wr && sw_we && !legacy |=> cr2 == $past(fault_addr));
endmodule

// File: rtl/page_fault_detector.sv
module page_fault_detector
    import pfd_pkg::*;
#(
    parameter int unsigned LEVELS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_valid,
    input  logic [1:0]         acc_kind,
    input  logic               acc_user,
    input  logic [VA_W-1:0]    acc_addr,
    input  logic [LEVELS-1:0]  lvl_present,
    input  logic [LEVELS-1:0]  lvl_writable,
    input  logic [LEVELS-1:0]  lvl_user,
    input  logic [LEVELS-1:0]  lvl_noexec,
    input  logic [LEVELS-1:0]  lvl_rsvd,
    input  logic               cr4_pse,
    input  logic               cr4_pae,
    input  logic               legacy_mode,
    input  logic               wp_enable,
    input  logic               sw_cr2_we,
    input  logic [VA_W-1:0]    sw_cr2_wdata,
    output logic               pf_valid,
    output logic [VEC_W-1:0]   pf_vector,
    output logic [ERR_W-1:0]   pf_errcode,
    output logic [VA_W-1:0]    cr2
);
    walk_sum_t sum;
    pf_err_t   err_c, err_q;
    logic      fault_c, take;

    pfd_walk_merge #(.LEVELS(LEVELS)) u_merge (
        .present (lvl_present),
        .writable(lvl_writable),
        .user    (lvl_user),
        .noexec  (lvl_noexec),
        .rsvd    (lvl_rsvd),
        .sum     (sum)
    );

    pfd_fault_eval u_eval (
        .kind   (acc_kind),
        .is_user(acc_user),
        .sum    (sum),
        .pse    (cr4_pse),
        .pae    (cr4_pae),
        .wp     (wp_enable),
        .fault  (fault_c),
        .err    (err_c)
    );

    assign take = acc_valid & fault_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            pf_valid <= 1'b0;
            err_q    <= '0;
        end else begin
            pf_valid <= take;
            if (take) err_q <= err_c;
        end
    end

    pfd_cr2_reg u_cr2 (
        .clk       (clk),
        .rst       (rst),
        .fault_wr  (take),
        .fault_addr(acc_addr),
        .sw_we     (sw_cr2_we),
        .sw_data   (sw_cr2_wdata),
        .legacy    (legacy_mode),
        .cr2       (cr2)
    );

    assign pf_errcode = err_q;
    assign pf_vector  = pf_valid ? VEC_W'(PF_VECTOR) : '0;

    // R1
    not_present_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !(&lvl_present) |=> pf_valid && !pf_errcode[0] && !pf_errcode[3]);
    // R2
    noexec_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_kind == 2'b10 && (&lvl_present) && (|lvl_noexec)
        |=> pf_valid && pf_errcode[4]);
    // R5
    rsvd_gate_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !cr4_pse && !cr4_pae |=> !(pf_valid && pf_errcode[3]));
    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !pf_valid);
    // R7
    addr_capture_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !legacy_mode && !(&lvl_present) |=> cr2 == $past(acc_addr));
endmodule

// File: tb/page_fault_detector_bench.sv
`timescale 1ns/1ps
module page_fault_detector_bench;
    localparam int L = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_valid = 1'b0;
    logic [1:0] acc_kind = 2'b00;
    logic acc_user = 1'b0;
    logic [63:0] acc_addr = '0;
    logic [L-1:0] lvl_present = '1, lvl_writable = '1, lvl_user = '1;
    logic [L-1:0] lvl_noexec = '0, lvl_rsvd = '0;
    logic cr4_pse = 1'b0, cr4_pae = 1'b0, legacy_mode = 1'b0, wp_enable = 1'b0;
    logic sw_cr2_we = 1'b0;
    logic [63:0] sw_cr2_wdata = '0;
    logic pf_valid;
    logic [7:0] pf_vector;
    logic [4:0] pf_errcode;
    logic [63:0] cr2;

    int checks = 0, fails = 0;
    string cur_req = "R11";
    bit exp_valid = 0;
    logic [4:0] exp_err = '0;
    logic [63:0] exp_cr2 = '0;

    always #2 clk = ~clk;

    page_fault_detector #(.LEVELS(L)) u_page_fault_detector (.*);

    // behavioural reference: returns fault flag, code through ref
    function automatic bit ref_fault(output logic [4:0] code);
        bit allp = 1, wr_ok = 1, us_ok = 1, nx = 0, rs = 0, f;
        bit is_wr = (acc_kind == 2'b01);
        bit is_fx = (acc_kind == 2'b10);
        bit rs_hit;
        for (int i = 0; i < L; i++) begin
            if (!lvl_present[i]) allp = 0;
            if (!lvl_writable[i]) wr_ok = 0;
            if (!lvl_user[i]) us_ok = 0;
            if (lvl_noexec[i]) nx = 1;
            if (lvl_rsvd[i]) rs = 1;
        end
        rs_hit = allp && rs && (cr4_pse || cr4_pae);
        if (!allp) f = 1;
        else f = rs_hit || (acc_user && !us_ok) || (is_fx && nx)
               || (is_wr && !wr_ok && (acc_user || wp_enable));
        code = {is_fx, rs_hit, acc_user, is_wr, allp};
        return f;
    endfunction

    function automatic logic [63:0] lg(input logic [63:0] v);
        return legacy_mode ? {32'h0, v[31:0]} : v;
    endfunction

    always @(posedge clk) begin
        logic [4:0] c;
        bit f;
        if (rst) begin
            exp_valid = 0; exp_err = '0; exp_cr2 = '0;
        end else begin
            f = ref_fault(c);
            exp_valid = acc_valid && f;
            if (exp_valid) begin
                exp_err = c;
                exp_cr2 = lg(acc_addr);
            end else if (sw_cr2_we) begin
                exp_cr2 = lg(sw_cr2_wdata);
            end
        end
    end

    task automatic compare();
        logic [7:0] ev;
        ev = exp_valid ? 8'd14 : 8'd0;
        checks++;
        if (pf_valid !== exp_valid || pf_vector !== ev || pf_errcode !== exp_err
            || cr2 !== exp_cr2) begin
            fails++;
            $display("FAIL %s: valid=%0b vec=%0d err=%05b cr2=%h expected valid=%0b vec=%0d err=%05b cr2=%h",
                     cur_req, pf_valid, pf_vector, pf_errcode, cr2,
                     exp_valid, ev, exp_err, exp_cr2);
        end
    endtask

    task automatic step(input string req);
        cur_req = req;
        @(posedge clk);
        @(negedge clk);
        compare();
        acc_valid = 0; sw_cr2_we = 0;
    endtask

    task automatic walk(input logic [1:0] k, input logic u, input logic [63:0] a,
                        input logic [L-1:0] p, input logic [L-1:0] w,
                        input logic [L-1:0] us, input logic [L-1:0] nx,
                        input logic [L-1:0] rs);
        acc_valid = 1; acc_kind = k; acc_user = u; acc_addr = a;
        lvl_present = p; lvl_writable = w; lvl_user = us;
        lvl_noexec = nx; lvl_rsvd = rs;
    endtask

    bit done = 0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R11";
        compare();
        rst = 0;
        step("R11");

        // R1 not present
        walk(2'b00, 0, 64'h0000_1234_5678_9000, 4'b1011, '1, '1, '0, '0); step("R1");
        walk(2'b01, 1, 64'h0000_0000_0000_4000, 4'b0111, '1, '1, '0, 4'b1111);
        cr4_pae = 1; step("R1"); cr4_pae = 0;
        // R2 no-execute
        walk(2'b10, 0, 64'h7fff_0000_0000_1000, '1, '1, '1, 4'b0100, '0); step("R2");
        walk(2'b10, 0, 64'h7fff_0000_0000_2000, '1, '1, '1, '0, '0); step("R2");
        // R3 user flags
        walk(2'b00, 1, 64'h0000_0000_dead_b000, '1, '1, 4'b1101, '0, '0); step("R3");
        walk(2'b00, 0, 64'h0000_0000_dead_c000, '1, '1, 4'b0000, '0, '0); step("R3");
        // R4 write permission
        walk(2'b01, 1, 64'h0000_0000_0bad_0000, '1, 4'b1110, '1, '0, '0); step("R4");
        wp_enable = 0;
        walk(2'b01, 0, 64'h0000_0000_0bad_1000, '1, 4'b1110, '1, '0, '0); step("R4");
        wp_enable = 1;
        walk(2'b01, 0, 64'h0000_0000_0bad_2000, '1, 4'b1110, '1, '0, '0); step("R4");
        walk(2'b11, 1, 64'h0000_0000_0bad_3000, '1, 4'b0000, '1, '0, '0); step("R4");
        wp_enable = 0;
        // R5 reserved bits
        walk(2'b00, 0, 64'h0000_0000_1111_0000, '1, '1, '1, '0, 4'b0010); step("R5");
        cr4_pae = 1;
        walk(2'b00, 0, 64'h0000_0000_1111_1000, '1, '1, '1, '0, 4'b0010); step("R5");
        cr4_pae = 0; cr4_pse = 1;
        walk(2'b01, 1, 64'h0000_0000_1111_2000, '1, '1, '1, '0, 4'b1000); step("R5");
        cr4_pse = 0;
        // R6 no fault leaves outputs, idle
        walk(2'b00, 1, 64'h0000_0000_2222_0000, '1, '1, '1, '0, '0); step("R6");
        step("R6");
        // R7 full-width capture
        walk(2'b00, 0, 64'hfedc_ba98_7654_3000, 4'b0000, '0, '0, '0, '0); step("R7");
        // R8 legacy
        legacy_mode = 1;
        walk(2'b00, 0, 64'hffff_ffff_c000_1000, 4'b0001, '1, '1, '0, '0); step("R8");
        sw_cr2_we = 1; sw_cr2_wdata = 64'haaaa_bbbb_cccc_dddd; step("R8");
        legacy_mode = 0;
        // R9 software write, hold
        sw_cr2_we = 1; sw_cr2_wdata = 64'h0123_4567_89ab_cdef; step("R9");
        step("R9");
        // R10 priority
        walk(2'b10, 1, 64'h8000_0000_0000_0040, '1, '1, '1, 4'b1000, '0);
        sw_cr2_we = 1; sw_cr2_wdata = 64'h5555_5555_5555_5555; step("R10");
        walk(2'b00, 0, 64'h8000_0000_0000_0080, '1, '1, '1, '0, '0);
        sw_cr2_we = 1; sw_cr2_wdata = 64'h6666_6666_6666_6666; step("R10");

        // R6 random phase
        for (int n = 0; n < 3000; n++) begin
            acc_valid = $urandom_range(0, 1);
            acc_kind = 2'($urandom_range(0, 3));
            acc_user = $urandom_range(0, 1);
            acc_addr = {$urandom(), $urandom()};
            lvl_present = ($urandom_range(0, 3) == 0) ? 4'($urandom()) : '1;
            lvl_writable = ($urandom_range(0, 1) == 0) ? 4'($urandom()) : '1;
            lvl_user = ($urandom_range(0, 1) == 0) ? 4'($urandom()) : '1;
            lvl_noexec = ($urandom_range(0, 2) == 0) ? 4'($urandom()) : '0;
            lvl_rsvd = ($urandom_range(0, 2) == 0) ? 4'($urandom()) : '0;
            cr4_pse = $urandom_range(0, 1);
            cr4_pae = $urandom_range(0, 1);
            legacy_mode = ($urandom_range(0, 3) == 0);
            wp_enable = $urandom_range(0, 1);
            sw_cr2_we = ($urandom_range(0, 3) == 0);
            sw_cr2_wdata = {$urandom(), $urandom()};
            step("R6");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule